// File: doc/BRIEF.md
# Dual-Accumulator Arithmetic Execute Unit

This block is the execute stage of a small fixed-point signal processor. It holds two 40-bit signed accumulators and two 32-bit secondary accumulators. Each secondary accumulator is made of a low and a high 16-bit word. The block takes 16-bit opcodes, carries out the arithmetic and logic group, and keeps three status flags: zero, negative and overflow. The flags are always computed over the whole 40-bit result, even when an operation only works on the middle word of an accumulator. The product value comes in on a port from the multiplier and is used directly.

Opcodes that need a second 16-bit word are handled by a two-state machine:

- `ST_IDLE` accepts a new opcode.
- `ST_WAIT_IMM` holds the first word until the immediate arrives.

There are two transitions:

- *fetch-second-word* goes from `ST_IDLE` to `ST_WAIT_IMM`. It is taken when a valid opcode needs an immediate.
- *immediate-taken* goes from `ST_WAIT_IMM` back to `ST_IDLE`. It is taken when `imm_valid` is high, and the operation executes in that same cycle.

A 16-bit word-load port, used by the surrounding pipeline for register moves, writes single words of the register state. It only acts when no opcode is being offered.

Top module: `dsp_dual_acc_unit`

## Requirements
- R1: After reset, both accumulators, both secondary accumulators and all three flags are zero, and `imm_wait` is 0.
- R2: Opcode bit 8 selects the destination accumulator. INC (bits 15:9 = 0111011) adds 1 and DEC (0111101) subtracts 1 at bit 0 of the 40-bit accumulator.
- R3: INCM (0111010) adds 2^16 and DECM (0111100) subtracts 2^16, which is one unit of the middle portion.
- R4: NEG (0111110) replaces the accumulator with its two's complement. Negating the most negative value leaves it unchanged and sets overflow.
- R5: SUB (0101110) writes acc[d] minus acc[1-d] into acc[d]. SUBP (0101111) writes acc[d] minus the 40-bit product input.
- R6: SUBAX (bits 15:10 = 010110, bit 9 = s) subtracts secondary accumulator s, sign-extended from 32 bits, from acc[d].
- R7: SUBR (bits 15:11 = 01010) subtracts and ADDR (01000) adds a 16-bit word taken from bits 10:9. The word is sign-extended and shifted left by 16 before use. The word selected is: 0 = secondary 0 low, 1 = secondary 1 low, 2 = secondary 0 high, 3 = secondary 1 high.
- R8: XORI, ANDI and ORI (bits 15:9 = 0000001, low byte 0x20, 0x40, 0x60) apply their operation with the second word to bits 31:16 of acc[d] only. Overflow is cleared, and zero and negative come from the 40-bit result.
- R9: CMPIS (0000011, low byte = 8-bit immediate) and CMPI (0000001, low byte 0x80, second word as immediate) subtract the sign-extended immediate, shifted left 16, from acc[d]. They set the flags from that difference and leave both accumulators unchanged.
- R10: Results wrap modulo 2^40. Zero means the result is 0, negative is bit 39, and overflow means the true signed result is outside the 40-bit range.
- R11: After a first word that needs an immediate, `imm_wait` is 1. Further opcodes are ignored and the register state holds until `imm_valid`. `imm_valid` has no effect in `ST_IDLE`.
- R12: An unrecognised opcode changes no register and no flag.
- R13: A word load writes one 16-bit word at `ld_idx` and leaves the flags unchanged. The index map is: 0/1/2 = acc0 low/mid/high (high takes data bits 7:0), 3/4/5 = acc1 low/mid/high, 6/7 = secondary 0 low/high, 8/9 = secondary 1 low/high. A load is ignored while an opcode is offered or during `ST_WAIT_IMM`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode word is offered |
| op_word | input | 16 | Opcode word |
| imm_valid | input | 1 | Second (immediate) word is offered |
| imm_word | input | 16 | Immediate word |
| prod_in | input | 40 | Product register value |
| ld_valid | input | 1 | Word-load request |
| ld_idx | input | 4 | Word-load target index |
| ld_data | input | 16 | Word-load data |
| acc0_out | output | 40 | Accumulator 0 |
| acc1_out | output | 40 | Accumulator 1 |
| ax0_out | output | 32 | Secondary accumulator 0 (high:low) |
| ax1_out | output | 32 | Secondary accumulator 1 (high:low) |
| flag_zero | output | 1 | Zero flag |
| flag_neg | output | 1 | Negative flag |
| flag_ovf | output | 1 | Overflow flag |
| imm_wait | output | 1 | Machine is in `ST_WAIT_IMM` |

## Verification
The directed part of the test works through each opcode with both values of the destination bit. Running the same operation on acc0 and on acc1 shows whether the select bit is honoured. It also drives values chosen to sit on the 2^39 boundary and the wrap points: INC of the largest positive value, DEC of zero, NEG of the most negative value, and subtractions whose operand signs differ. These are the values that separate a correct overflow rule from one that only looks at the carry. Logic operations are run on accumulators whose top and bottom bytes are non-zero, which shows that only the middle word changes. Compares are run with negative immediates, which shows that the sign extension is applied and that nothing is written back. A random stream of opcodes and loads then mixes everything, including stray opcodes offered while an immediate is pending, and the outputs are compared against a behavioural model on every cycle.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;
    localparam int ACC_W   = 40;
    localparam int WORD_W  = 16;
    localparam int MID_LSB = 16;
    localparam int AX_W    = 2 * WORD_W;
    localparam int HI_W    = ACC_W - 2 * WORD_W;
    localparam int SIMM_W  = 8;

    typedef enum logic [0:0] {ST_IDLE, ST_WAIT_IMM} state_e;

    typedef enum logic [3:0] {
        OP_NONE, OP_INC, OP_DEC, OP_INCM, OP_DECM, OP_NEG, OP_SUB, OP_SUBP,
        OP_SUBAX, OP_SUBR, OP_ADDR, OP_XORI, OP_ANDI, OP_ORI, OP_CMPI, OP_CMPIS
    } op_e;

    typedef struct packed {
        op_e               kind;
        logic              dst;
        logic [1:0]        src;
        logic [SIMM_W-1:0] short_imm;
        logic              two_word;
    } dec_t;
endpackage

// File: rtl/dsp_acc_decode.sv
module dsp_acc_decode
    import dsp_acc_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o           = '0;
        dec_o.kind      = OP_NONE;
        dec_o.dst       = word_i[8];
        dec_o.src       = word_i[10:9];
        dec_o.short_imm = word_i[SIMM_W-1:0];
        casez (word_i[15:9])
            7'b0111011: dec_o.kind = OP_INC;
            7'b0111101: dec_o.kind = OP_DEC;
            7'b0111010: dec_o.kind = OP_INCM;
            7'b0111100: dec_o.kind = OP_DECM;
            7'b0111110: dec_o.kind = OP_NEG;
            7'b0101111: dec_o.kind = OP_SUBP;
            7'b0101110: dec_o.kind = OP_SUB;
            7'b010110?: dec_o.kind = OP_SUBAX;
            7'b01010??: dec_o.kind = OP_SUBR;
            7'b01000??: dec_o.kind = OP_ADDR;
            7'b0000011: dec_o.kind = OP_CMPIS;
            7'b0000001: begin
                dec_o.two_word = 1'b1;
                case (word_i[7:0])
                    8'h20:   dec_o.kind = OP_XORI;
                    8'h40:   dec_o.kind = OP_ANDI;
                    8'h60:   dec_o.kind = OP_ORI;
                    8'h80:   dec_o.kind = OP_CMPI;
                    default: begin
                        dec_o.kind     = OP_NONE;
                        dec_o.two_word = 1'b0;
                    end
                endcase
            end
            default: dec_o.kind = OP_NONE;
        endcase
    end
endmodule

// File: rtl/dsp_acc_alu.sv
module dsp_acc_alu
    import dsp_acc_pkg::*;
(
    input  op_e               kind_i,
    input  logic [1:0]        src_i,
    input  logic [SIMM_W-1:0] short_imm_i,
    input  logic [ACC_W-1:0]  acc_d_i,
    input  logic [ACC_W-1:0]  acc_o_i,
    input  logic [ACC_W-1:0]  prod_i,
    input  logic [AX_W-1:0]   ax0_i,
    input  logic [AX_W-1:0]   ax1_i,
    input  logic [WORD_W-1:0] imm_i,
    output logic [ACC_W-1:0]  res_o,
    output logic              wb_o,
    output logic              upd_o,
    output logic              fz_o,
    output logic              fn_o,
    output logic              fv_o
);
    localparam int MSB  = ACC_W - 1;
    localparam int PADW = ACC_W - WORD_W - MID_LSB;
    localparam int PADS = ACC_W - SIMM_W - MID_LSB;

    logic [WORD_W-1:0] reg16;
    logic [AX_W-1:0]   ax_sel;
    logic [ACC_W-1:0]  a, b, sum, logic_res;
    logic              sub, is_logic, v_arith;

    always_comb begin
        unique case (src_i)
            2'd0: reg16 = ax0_i[WORD_W-1:0];
            2'd1: reg16 = ax1_i[WORD_W-1:0];
            2'd2: reg16 = ax0_i[AX_W-1:WORD_W];
            default: reg16 = ax1_i[AX_W-1:WORD_W];
        endcase
        ax_sel = src_i[0] ? ax1_i : ax0_i;
    end

    always_comb begin
        a        = acc_d_i;
        b        = '0;
        sub      = 1'b0;
        wb_o     = 1'b1;
        upd_o    = 1'b1;
        is_logic = 1'b0;
        logic_res = acc_d_i;
        unique case (kind_i)
            OP_INC:   b = ACC_W'(1);
            OP_DEC:   begin b = ACC_W'(1); sub = 1'b1; end
            OP_INCM:  b = ACC_W'(1) << MID_LSB;
            OP_DECM:  begin b = ACC_W'(1) << MID_LSB; sub = 1'b1; end
            OP_NEG:   begin a = '0; b = acc_d_i; sub = 1'b1; end
            OP_SUB:   begin b = acc_o_i; sub = 1'b1; end
            OP_SUBP:  begin b = prod_i; sub = 1'b1; end
            OP_SUBAX: begin b = {{(ACC_W-AX_W){ax_sel[AX_W-1]}}, ax_sel}; sub = 1'b1; end
            OP_SUBR:  begin b = {{PADW{reg16[WORD_W-1]}}, reg16, {MID_LSB{1'b0}}}; sub = 1'b1; end
            OP_ADDR:  b = {{PADW{reg16[WORD_W-1]}}, reg16, {MID_LSB{1'b0}}};
            OP_CMPI:  begin b = {{PADW{imm_i[WORD_W-1]}}, imm_i, {MID_LSB{1'b0}}}; sub = 1'b1; wb_o = 1'b0; end
            OP_CMPIS: begin
                b = {{PADS{short_imm_i[SIMM_W-1]}}, short_imm_i, {MID_LSB{1'b0}}};
                sub = 1'b1; wb_o = 1'b0;
            end
            OP_XORI:  begin is_logic = 1'b1; logic_res[MID_LSB +: WORD_W] = acc_d_i[MID_LSB +: WORD_W] ^ imm_i; end
            OP_ANDI:  begin is_logic = 1'b1; logic_res[MID_LSB +: WORD_W] = acc_d_i[MID_LSB +: WORD_W] & imm_i; end
            OP_ORI:   begin is_logic = 1'b1; logic_res[MID_LSB +: WORD_W] = acc_d_i[MID_LSB +: WORD_W] | imm_i; end
            default:  begin wb_o = 1'b0; upd_o = 1'b0; end
        endcase
    end

    assign sum     = sub ? (a - b) : (a + b);
    assign v_arith = sub ? ((a[MSB] ^ b[MSB]) & (sum[MSB] ^ a[MSB]))
                         : (~(a[MSB] ^ b[MSB]) & (sum[MSB] ^ a[MSB]));
    assign res_o   = is_logic ? logic_res : sum;
    assign fz_o    = (res_o == '0);
    assign fn_o    = res_o[MSB];
    assign fv_o    = is_logic ? 1'b0 : v_arith;
endmodule

// File: rtl/dsp_dual_acc_unit.sv
module dsp_dual_acc_unit
    import dsp_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_word,
    input  logic              imm_valid,
    input  logic [WORD_W-1:0] imm_word,
    input  logic [ACC_W-1:0]  prod_in,
    input  logic              ld_valid,
    input  logic [3:0]        ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    output logic [ACC_W-1:0]  acc0_out,
    output logic [ACC_W-1:0]  acc1_out,
    output logic [AX_W-1:0]   ax0_out,
    output logic [AX_W-1:0]   ax1_out,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              flag_ovf,
    output logic              imm_wait
);
    localparam int NUM_ACC   = 2;
    localparam int ACC_SLOTS = 3;
    localparam int AX_BASE   = NUM_ACC * ACC_SLOTS;

    state_e            state_q, state_d;
    logic [WORD_W-1:0] op_hold_q, cur_word;
    dec_t              dec;
    logic [ACC_W-1:0]  acc_q [NUM_ACC];
    logic [AX_W-1:0]   ax_q  [NUM_ACC];
    logic [ACC_W-1:0]  alu_res;
    logic              alu_wb, alu_upd, alu_z, alu_n, alu_v;
    logic              exec, ld_fire;

    assign cur_word = (state_q == ST_WAIT_IMM) ? op_hold_q : op_word;

    dsp_acc_decode u_dec (.word_i(cur_word), .dec_o(dec));

    dsp_acc_alu u_alu (
        .kind_i(dec.kind), .src_i(dec.src), .short_imm_i(dec.short_imm),
        .acc_d_i(acc_q[dec.dst]), .acc_o_i(acc_q[~dec.dst]), .prod_i(prod_in),
        .ax0_i(ax_q[0]), .ax1_i(ax_q[1]), .imm_i(imm_word),
        .res_o(alu_res), .wb_o(alu_wb), .upd_o(alu_upd),
        .fz_o(alu_z), .fn_o(alu_n), .fv_o(alu_v)
    );

    assign exec    = ((state_q == ST_IDLE) && op_valid && !dec.two_word) ||
                     ((state_q == ST_WAIT_IMM) && imm_valid);
    assign ld_fire = (state_q == ST_IDLE) && !op_valid && ld_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (op_valid && dec.two_word) state_d = ST_WAIT_IMM;
            ST_WAIT_IMM: if (imm_valid) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_hold_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && op_valid) op_hold_q <= op_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ACC; i++) begin
                acc_q[i] <= '0;
                ax_q[i]  <= '0;
            end
            flag_zero <= 1'b0;
            flag_neg  <= 1'b0;
            flag_ovf  <= 1'b0;
        end else if (exec) begin
            if (alu_upd) begin
                flag_zero <= alu_z;
                flag_neg  <= alu_n;
                flag_ovf  <= alu_v;
            end
            if (alu_wb) acc_q[dec.dst] <= alu_res;
        end else if (ld_fire) begin
            for (int i = 0; i < NUM_ACC; i++) begin
                if (ld_idx == 4'(ACC_SLOTS*i))     acc_q[i][WORD_W-1:0]          <= ld_data;
                if (ld_idx == 4'(ACC_SLOTS*i + 1)) acc_q[i][MID_LSB +: WORD_W]   <= ld_data;
                if (ld_idx == 4'(ACC_SLOTS*i + 2)) acc_q[i][ACC_W-1:2*WORD_W]    <= ld_data[HI_W-1:0];
                if (ld_idx == 4'(AX_BASE + 2*i))     ax_q[i][WORD_W-1:0]         <= ld_data;
                if (ld_idx == 4'(AX_BASE + 2*i + 1)) ax_q[i][AX_W-1:WORD_W]      <= ld_data;
            end
        end
    end

    assign acc0_out = acc_q[0];
    assign acc1_out = acc_q[1];
    assign ax0_out  = ax_q[0];
    assign ax1_out  = ax_q[1];
    assign imm_wait = (state_q == ST_WAIT_IMM);

    AST_ENTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_wait && op_valid && dec.two_word) |=> imm_wait); // R11
    AST_WAIT_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_wait && !imm_valid) |=> ($stable(acc0_out) && $stable(acc1_out) &&
                                      $stable(ax0_out) && $stable(ax1_out) && imm_wait)); // R11
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && alu_upd && !alu_wb) |=> ($stable(acc0_out) && $stable(acc1_out))); // R9
    AST_ZERO_MATCHES_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && alu_wb) |=> (flag_zero == (($past(dec.dst) ? acc1_out : acc0_out) == '0))); // R10
    AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fire |=> $stable({flag_zero, flag_neg, flag_ovf})); // R13
endmodule

// File: tb/dsp_dual_acc_unit_test.sv
`timescale 1ns/1ps
module dsp_dual_acc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, imm_valid = 1'b0, ld_valid = 1'b0;
    logic [15:0] op_word = '0, imm_word = '0, ld_data = '0;
    logic [3:0]  ld_idx = '0;
    logic [39:0] prod_in = '0;
    logic [39:0] acc0_out, acc1_out;
    logic [31:0] ax0_out, ax1_out;
    logic        flag_zero, flag_neg, flag_ovf, imm_wait;

    int checks = 0, failures = 0;
    bit done = 0;

    // model state
    logic [39:0] m_acc [2];
    logic [31:0] m_ax  [2];
    logic        m_z, m_n, m_v, m_wait;

    always #10 clk = ~clk;

    dsp_dual_acc_unit uut (.*);

    function automatic longint sx40(logic [39:0] x);
        return longint'({{24{x[39]}}, x});
    endfunction

    function automatic longint sxn(logic [15:0] x);
        return longint'({{48{x[15]}}, x});
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "acc0", longint'(acc0_out), longint'(m_acc[0]));
        chk(tag, "acc1", longint'(acc1_out), longint'(m_acc[1]));
        chk(tag, "ax0",  longint'(ax0_out),  longint'(m_ax[0]));
        chk(tag, "ax1",  longint'(ax1_out),  longint'(m_ax[1]));
        chk(tag, "flags", longint'({flag_zero, flag_neg, flag_ovf}), longint'({m_z, m_n, m_v}));
        chk(tag, "wait", longint'(imm_wait), longint'(m_wait));
    endtask

    function automatic bit needs_imm(logic [15:0] w);
        return (w[15:9] == 7'b0000001) &&
               (w[7:0] == 8'h20 || w[7:0] == 8'h40 || w[7:0] == 8'h60 || w[7:0] == 8'h80);
    endfunction

    // behavioural execution of one operation on the model
    task automatic model_exec(logic [15:0] w, logic [15:0] imm);
        int d = int'(w[8]);
        longint a = sx40(m_acc[d]);
        longint t = 0;
        bit arith = 1, wr = 1, known = 1;
        logic [39:0] r;
        logic [15:0] r16;
        logic [31:0] axs;
        int ss = int'(w[10:9]);
        r16 = (ss == 0) ? m_ax[0][15:0] : (ss == 1) ? m_ax[1][15:0] :
              (ss == 2) ? m_ax[0][31:16] : m_ax[1][31:16];
        axs = m_ax[int'(w[9])];
        r = m_acc[d];
        if      (w[15:9] == 7'b0111011) t = a + 1;
        else if (w[15:9] == 7'b0111101) t = a - 1;
        else if (w[15:9] == 7'b0111010) t = a + 65536;
        else if (w[15:9] == 7'b0111100) t = a - 65536;
        else if (w[15:9] == 7'b0111110) t = -a;
        else if (w[15:9] == 7'b0101110) t = a - sx40(m_acc[1-d]);
        else if (w[15:9] == 7'b0101111) t = a - sx40(prod_in);
        else if (w[15:10] == 6'b010110) t = a - longint'({{32{axs[31]}}, axs});
        else if (w[15:11] == 5'b01010)  t = a - sxn(r16) * 65536;
        else if (w[15:11] == 5'b01000)  t = a + sxn(r16) * 65536;
        else if (w[15:9] == 7'b0000011) begin t = a - longint'({{56{w[7]}}, w[7:0]}) * 65536; wr = 0; end
        else if (w[15:9] == 7'b0000001 && w[7:0] == 8'h80) begin t = a - sxn(imm) * 65536; wr = 0; end
        else if (w[15:9] == 7'b0000001 && w[7:0] == 8'h20) begin arith = 0; r[31:16] = r[31:16] ^ imm; end
        else if (w[15:9] == 7'b0000001 && w[7:0] == 8'h40) begin arith = 0; r[31:16] = r[31:16] & imm; end
        else if (w[15:9] == 7'b0000001 && w[7:0] == 8'h60) begin arith = 0; r[31:16] = r[31:16] | imm; end
        else known = 0;
        if (!known) return;
        if (arith) begin
            r   = t[39:0];
            m_v = (t > 64'sd549755813887) || (t < -64'sd549755813888);
        end else m_v = 0;
        m_z = (r == 0);
        m_n = r[39];
        if (wr) m_acc[d] = r;
    endtask

    task automatic op1(logic [15:0] w, string tag);
        @(negedge clk);
        op_valid = 1; op_word = w;
        model_exec(w, imm_word);
        @(negedge clk);
        op_valid = 0;
        check_all(tag);
    endtask

    // two-word op with a one-cycle stall and a stray opcode offered during the wait
    task automatic op2(logic [15:0] w, logic [15:0] imm, string tag);
        @(negedge clk);
        op_valid = 1; op_word = w;
        @(negedge clk);
        m_wait = 1;
        op_word = 16'h7600; // INC acc0, must be ignored (R11)
        check_all("R11");
        @(negedge clk);
        op_valid = 0;
        check_all("R11");
        imm_valid = 1; imm_word = imm;
        model_exec(w, imm);
        m_wait = 0;
        @(negedge clk);
        imm_valid = 0;
        check_all(tag);
    endtask

    task automatic ld(logic [3:0] idx, logic [15:0] data, string tag);
        @(negedge clk);
        ld_valid = 1; ld_idx = idx; ld_data = data;
        case (idx)
            4'd0: m_acc[0][15:0]  = data;
            4'd1: m_acc[0][31:16] = data;
            4'd2: m_acc[0][39:32] = data[7:0];
            4'd3: m_acc[1][15:0]  = data;
            4'd4: m_acc[1][31:16] = data;
            4'd5: m_acc[1][39:32] = data[7:0];
            4'd6: m_ax[0][15:0]   = data;
            4'd7: m_ax[0][31:16]  = data;
            4'd8: m_ax[1][15:0]   = data;
            4'd9: m_ax[1][31:16]  = data;
            default: ;
        endcase
        @(negedge clk);
        ld_valid = 0;
        check_all(tag);
    endtask

    task automatic set_acc(int d, logic [39:0] v);
        ld(4'(3*d),     v[15:0],        "R13");
        ld(4'(3*d + 1), v[31:16],       "R13");
        ld(4'(3*d + 2), {8'h00, v[39:32]}, "R13");
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_acc[0] = '0; m_acc[1] = '0; m_ax[0] = '0; m_ax[1] = '0;
        m_z = 0; m_n = 0; m_v = 0; m_wait = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R2: INC/DEC on both destinations, wrap and overflow edges
        op1(16'h7600, "R2");
        op1(16'h7700, "R2");
        op1(16'h7b00, "R2");
        op1(16'h7b00, "R2");               // acc1 0 -> -1
        set_acc(0, 40'h7f_ffff_ffff);
        op1(16'h7600, "R10");              // positive overflow
        op1(16'h7a00, "R10");              // back down, overflow again
        // R3
        op1(16'h7400, "R3");
        op1(16'h7900, "R3");
        // R4
        set_acc(1, 40'h80_0000_0000);
        op1(16'h7d00, "R4");
        set_acc(0, 40'h00_1234_5678);
        op1(16'h7c00, "R4");
        // R5
        op1(16'h5c00, "R5");
        op1(16'h5d00, "R5");
        prod_in = 40'hff_0000_0001;
        op1(16'h5e00, "R5");
        prod_in = 40'h00_8000_0000;
        op1(16'h5f00, "R5");
        // R6
        ld(4'd6, 16'hbeef, "R13"); ld(4'd7, 16'h8001, "R13");
        ld(4'd8, 16'h0102, "R13"); ld(4'd9, 16'h7fff, "R13");
        op1(16'h5800, "R6");
        op1(16'h5a01, "R6");
        op1(16'h5b00, "R6");
        // R7
        for (int s = 0; s < 4; s++) begin
            op1(16'h5000 | 16'(s << 9), "R7");
            op1(16'h4100 | 16'(s << 9), "R7");
        end
        // R8
        set_acc(0, 40'ha5_1234_5678);
        op2(16'h0220, 16'hffff, "R8");
        op2(16'h0240, 16'h0ff0, "R8");
        op2(16'h0260, 16'h8000, "R8");
        set_acc(1, 40'h00_00ff_0000);
        op2(16'h0340, 16'h0000, "R8");     // zero result
        // R9
        set_acc(0, 40'h00_0005_0000);
        op1(16'h0605, "R9");               // equal -> zero flag
        op1(16'h06fe, "R9");               // negative short imm
        op2(16'h0280, 16'h0006, "R9");
        op2(16'h0380, 16'h8000, "R9");
        // R11: imm_valid in idle
        @(negedge clk); imm_valid = 1; imm_word = 16'h1234;
        @(negedge clk); imm_valid = 0; check_all("R11");
        // R12: unknown opcodes
        op1(16'h0000, "R12");
        op1(16'h0210, "R12");
        op1(16'hffff, "R12");
        // R13: load ignored while an opcode is offered
        @(negedge clk);
        op_valid = 1; op_word = 16'h0000; ld_valid = 1; ld_idx = 4'd1; ld_data = 16'hdead;
        @(negedge clk);
        op_valid = 0; ld_valid = 0;
        check_all("R13");
        ld(4'd12, 16'h5555, "R13");

        // mixed random stream
        for (int k = 0; k < 400; k++) begin
            int pick = int'($urandom_range(0, 15));
            logic [15:0] w;
            prod_in = {$urandom, $urandom} ;
            case (pick)
                0:  w = 16'h7600; 1: w = 16'h7a00; 2: w = 16'h7400; 3: w = 16'h7800;
                4:  w = 16'h7c00; 5: w = 16'h5c00; 6: w = 16'h5e00; 7: w = 16'h5800;
                8:  w = 16'h5000; 9: w = 16'h4000; 10: w = 16'h0600;
                11: w = 16'h0220; 12: w = 16'h0240; 13: w = 16'h0260; 14: w = 16'h0280;
                default: w = 16'h0000;
            endcase
            w[10:8] = (pick >= 7 && pick <= 9) ? 3'($urandom) : {w[10:9], 1'($urandom)};
            if (pick == 10) w[7:0] = 8'($urandom);
            if (pick == 15) ld(4'($urandom_range(0, 9)), 16'($urandom), "R13");
            else if (needs_imm(w)) op2(w, 16'($urandom), "R10");
            else op1(w, "R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule